// File: doc/BRIEF.md
# Bus Hold and Snoop Write-back Controller

This block sequences the external bus of a write-back cached core. It runs three kinds of bus cycle: a four-transfer burst read that fills a cache line, a single-transfer code fetch that steps through the words of a line and starts each word with its own cycle-start strobe, and a four-transfer burst write that copies a modified line back to memory. An external agent may ask for the bus with a hold request. The block grants it only at a point where no cycle is broken up. A line fill always completes. A code fetch gives up the bus between two words.

While the bus is granted, the external agent may present a snoop. The cache tag lookup is modelled as a hit and dirty response that arrives in the same cycle as the snoop strobe. A hit with the invalidate flag set produces a one-cycle line-kill pulse. A hit on a dirty line raises the modified-hit output and records the snooped line. When the agent releases the bus, the block writes that line back. It then resumes any code fetch it had interrupted, with a new cycle-start at the next word. Word order within a line is word 0, 1, 2, 3, which is byte offset 0, 4, 8, C.

Top module: `bhs_ctrl`

## Requirements
- R1: If the hold request is high during a line fill, the grant stays low through all four burst transfers. It rises in the cycle after the fourth accepted burst ready.
- R2: From idle, the grant rises in the cycle after the hold request is sampled high. While granted, the grant falls in the cycle after the request is sampled low.
- R3: A snoop strobe is accepted only while granted, and only from the second cycle of the grant on. A strobe in the first granted cycle is ignored, so it gives no kill pulse and no modified hit.
- R4: On an accepted snoop, `line_kill_o` equals hit AND invalidate in that same cycle. `mod_hit_o` rises in the next cycle if hit AND dirty. A miss or a clean hit leaves `mod_hit_o` low. While a modified hit is pending, a further snoop is ignored.
- R5: The write-back cycle starts two cycles after the hold request is sampled low. It starts with `cyc_start_o`, `cacheable_o` and `write_o` all high, on the snooped line at word 0. After a miss or a clean hit, no cycle starts.
- R6: The write-back steps through words 0, 1, 2 and 3, one word per burst ready, and `last_xfer_o` is high on word 3. `mod_hit_o` stays high for the whole write-back and is low in the cycle after the fourth burst ready.
- R7: Each code-fetch word is a separate cycle with `cyc_start_o` high, `cacheable_o` low, `write_o` low and `last_xfer_o` high. If the hold request is high when a fetch transfer ready arrives, the grant is high in that same cycle.
- R8: After the write-back, the interrupted fetch restarts with a new `cyc_start_o`, on the same line at the word after the last completed one.
- R9: `cyc_start_o` is never high in a cycle in which the grant is high.
- R10: During reset, every output is low.
- R11: A line fill starts with `cyc_start_o` and `cacheable_o` high and `write_o` low. It then steps through words 0, 1, 2 and 3, with `last_xfer_o` high on word 3.
- R12: A transfer ready in a cycle where `cyc_start_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | External hold request for the bus |
| xfer_rdy_i | input | 1 | Single-transfer ready |
| burst_rdy_i | input | 1 | Burst-transfer ready |
| fill_req_i | input | 1 | Request for a line fill, taken only when idle |
| fill_line_i | input | LINE_W | Line address of the fill |
| fetch_req_i | input | 1 | Request for a code fetch, taken only when idle |
| fetch_line_i | input | LINE_W | Line address of the fetch |
| snp_strobe_i | input | 1 | Snoop address strobe |
| snp_inval_i | input | 1 | Snoop requests invalidation |
| snp_line_i | input | LINE_W | Snooped line address |
| snp_hit_i | input | 1 | Lookup result: line present |
| snp_dirty_i | input | 1 | Lookup result: line modified |
| bus_grant_o | output | 1 | Bus granted to the external agent |
| mod_hit_o | output | 1 | Snoop hit a modified line; write-back pending or running |
| line_kill_o | output | 1 | Invalidate the snooped line in the cache |
| cyc_start_o | output | 1 | Start of a bus cycle |
| cacheable_o | output | 1 | Current cycle is a burst line transfer |
| write_o | output | 1 | Current cycle writes memory |
| last_xfer_o | output | 1 | Current transfer is the last of its cycle |
| line_o | output | LINE_W | Line address of the current cycle |
| word_o | output | WORD_W | Word index within the line |

## Verification
Two functions can collide in the same cycle. The first is the completion of a bus transfer. The second is the arrival or release of the hold request. The bench raises the hold request while a line fill is under way and checks that the grant stays low on every burst transfer and rises only after the fourth one. It also raises the request on the same edge as a fetch transfer ready and checks that the grant is high in that very cycle. Snoop cases come from a table that covers each hit, dirty and invalidate combination. For each one the bench judges the kill pulse, the modified hit, and whether a write-back of the right line follows the release. The fetch case then checks that the interrupted fetch resumes at the correct word.

// File: rtl/bhs_pkg.sv
package bhs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_FETCH = 3'd2,
    ST_HELD  = 3'd3,
    ST_WB    = 3'd4
  } bhs_state_e;

  // word index after idx within a line of n words, wrapping to zero
  function automatic int unsigned next_idx(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  function automatic logic is_last(int unsigned idx, int unsigned n);
    return idx == n - 1;
  endfunction
endpackage

// File: rtl/bhs_beat_ctr.sv
module bhs_beat_ctr #(
  parameter int unsigned BEATS  = 4,
  localparam int unsigned WORD_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] idx_o,
  output logic              last_o
);
  logic [WORD_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) idx_q <= '0;
    else if (adv_i)        idx_q <= WORD_W'(bhs_pkg::next_idx(32'(idx_q), BEATS));
  end

  assign idx_o  = idx_q;
  assign last_o = bhs_pkg::is_last(32'(idx_q), BEATS);

  // R6 / R11: each accepted beat moves exactly one word forward
  a_r6_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clear_i && !last_o) |=> (idx_o == $past(idx_o) + WORD_W'(1)));
endmodule

// File: rtl/bhs_snoop_trk.sv
module bhs_snoop_trk #(
  parameter int unsigned LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              window_i,
  input  logic              strobe_i,
  input  logic              hit_i,
  input  logic              dirty_i,
  input  logic              inval_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              wb_done_i,
  output logic              pend_o,
  output logic              kill_o,
  output logic [LINE_W-1:0] wb_line_o
);
  logic              pend_q;
  logic [LINE_W-1:0] line_q;
  logic              accept, dirty_hit;

  assign accept    = window_i && strobe_i && !pend_q;
  assign dirty_hit = accept && hit_i && dirty_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      line_q <= '0;
    end else if (dirty_hit) begin
      pend_q <= 1'b1;
      line_q <= line_i;
    end else if (wb_done_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign kill_o    = accept && hit_i && inval_i;
  assign wb_line_o = line_q;

  a_r4_dirty_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_hit |=> pend_o);
  a_r4_clean_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !dirty_hit) |=> !pend_o);
  a_r3_kill_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    kill_o |-> window_i);
endmodule

// File: rtl/bhs_ctrl.sv
module bhs_ctrl #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned BEATS    = 4,
  parameter int unsigned WORD_B   = 4,
  localparam int unsigned WORD_W  = $clog2(BEATS),
  localparam int unsigned LINE_W  = ADDR_W - $clog2(BEATS * WORD_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  input  logic              xfer_rdy_i,
  input  logic              burst_rdy_i,
  input  logic              fill_req_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              fetch_req_i,
  input  logic [LINE_W-1:0] fetch_line_i,
  input  logic              snp_strobe_i,
  input  logic              snp_inval_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              snp_hit_i,
  input  logic              snp_dirty_i,
  output logic              bus_grant_o,
  output logic              mod_hit_o,
  output logic              line_kill_o,
  output logic              cyc_start_o,
  output logic              cacheable_o,
  output logic              write_o,
  output logic              last_xfer_o,
  output logic [LINE_W-1:0] line_o,
  output logic [WORD_W-1:0] word_o
);
  import bhs_pkg::*;

  bhs_state_e        st_q, st_d;
  logic              start_q, start_d;
  logic              grant_q;
  logic              resume_q, resume_d;
  logic [LINE_W-1:0] fill_line_q, fill_line_d;
  logic [LINE_W-1:0] fetch_line_q, fetch_line_d;
  logic [WORD_W-1:0] fetch_word_q, fetch_word_d;
  logic              beat_clr;

  // named internal events
  logic              rdy_ok;
  logic              burst_adv;
  logic              xfer_ok;
  logic              beat_last;
  logic              fetch_last;
  logic              wb_done;
  logic              snp_window;
  logic              wb_pend;
  logic [WORD_W-1:0] beat_idx;
  logic [LINE_W-1:0] wb_line;

  assign rdy_ok     = !start_q;
  assign burst_adv  = burst_rdy_i && rdy_ok && (st_q == ST_FILL || st_q == ST_WB);
  assign xfer_ok    = xfer_rdy_i && rdy_ok && (st_q == ST_FETCH);
  assign fetch_last = is_last(32'(fetch_word_q), BEATS);
  assign wb_done    = (st_q == ST_WB) && burst_adv && beat_last;
  assign snp_window = (st_q == ST_HELD) && grant_q;

  bhs_beat_ctr #(.BEATS(BEATS)) i_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (beat_clr),
    .adv_i   (burst_adv),
    .idx_o   (beat_idx),
    .last_o  (beat_last)
  );

  bhs_snoop_trk #(.LINE_W(LINE_W)) i_snoop (
    .clk       (clk),
    .rst_n     (rst_n),
    .window_i  (snp_window),
    .strobe_i  (snp_strobe_i),
    .hit_i     (snp_hit_i),
    .dirty_i   (snp_dirty_i),
    .inval_i   (snp_inval_i),
    .line_i    (snp_line_i),
    .wb_done_i (wb_done),
    .pend_o    (wb_pend),
    .kill_o    (line_kill_o),
    .wb_line_o (wb_line)
  );

  always_comb begin
    st_d         = st_q;
    start_d      = 1'b0;
    beat_clr     = 1'b0;
    resume_d     = resume_q;
    fill_line_d  = fill_line_q;
    fetch_line_d = fetch_line_q;
    fetch_word_d = fetch_word_q;
    case (st_q)
      ST_IDLE: begin
        if (wb_pend) begin
          st_d = ST_WB; start_d = 1'b1; beat_clr = 1'b1;
        end else if (resume_q) begin
          st_d = ST_FETCH; start_d = 1'b1; resume_d = 1'b0;
        end else if (bus_req_i) begin
          st_d = ST_HELD;
        end else if (fill_req_i) begin
          st_d = ST_FILL; start_d = 1'b1; beat_clr = 1'b1;
          fill_line_d = fill_line_i;
        end else if (fetch_req_i) begin
          st_d = ST_FETCH; start_d = 1'b1;
          fetch_line_d = fetch_line_i;
          fetch_word_d = '0;
        end
      end
      ST_FILL: begin
        if (burst_adv && beat_last) st_d = bus_req_i ? ST_HELD : ST_IDLE;
      end
      ST_FETCH: begin
        if (xfer_ok) begin
          if (fetch_last) begin
            st_d = bus_req_i ? ST_HELD : ST_IDLE;
          end else begin
            fetch_word_d = WORD_W'(next_idx(32'(fetch_word_q), BEATS));
            if (bus_req_i) begin
              st_d = ST_HELD; resume_d = 1'b1;
            end else begin
              start_d = 1'b1;
            end
          end
        end
      end
      ST_HELD: begin
        if (!bus_req_i) st_d = ST_IDLE;
      end
      ST_WB: begin
        if (wb_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      start_q      <= 1'b0;
      grant_q      <= 1'b0;
      resume_q     <= 1'b0;
      fill_line_q  <= '0;
      fetch_line_q <= '0;
      fetch_word_q <= '0;
    end else begin
      st_q         <= st_d;
      start_q      <= start_d;
      grant_q      <= bus_grant_o;
      resume_q     <= resume_d;
      fill_line_q  <= fill_line_d;
      fetch_line_q <= fetch_line_d;
      fetch_word_q <= fetch_word_d;
    end
  end

  // grant: held state, or a fetch transfer completing under a pending request
  assign bus_grant_o = (st_q == ST_HELD) || (xfer_ok && bus_req_i);
  assign mod_hit_o   = wb_pend;
  assign cyc_start_o = start_q;
  assign cacheable_o = (st_q == ST_FILL) || (st_q == ST_WB);
  assign write_o     = (st_q == ST_WB);
  assign last_xfer_o = (st_q == ST_FETCH) || (cacheable_o && beat_last);

  always_comb begin
    case (st_q)
      ST_FILL:  begin line_o = fill_line_q;  word_o = beat_idx;     end
      ST_WB:    begin line_o = wb_line;      word_o = beat_idx;     end
      ST_FETCH: begin line_o = fetch_line_q; word_o = fetch_word_q; end
      default:  begin line_o = '0;           word_o = '0;           end
    endcase
  end

  a_r1_fill_unbroken: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_grant_o) && $past(st_q == ST_FILL)) |-> $past(burst_adv && beat_last));
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HELD && !bus_req_i) |=> !bus_grant_o);
  a_r9_no_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant_o |-> !cyc_start_o);
  a_r5_wb_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start_o && write_o) |-> (!$past(bus_grant_o) && mod_hit_o));
  a_r6_hitm_covers_wb: assert property (@(posedge clk) disable iff (!rst_n)
    write_o |-> mod_hit_o);
  a_r12_start_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start_o && cacheable_o) |=> (word_o == '0));
endmodule

// File: tb/test_bhs_ctrl.sv
module test_bhs_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned LINE_W = 28;
  localparam int unsigned WORD_W = 2;

  // snoop table: {hit, dirty, inval, expect_modhit, expect_kill}
  localparam logic [4:0] SNP_TAB [6] = '{
    5'b11111, 5'b11010, 5'b10101, 5'b10000, 5'b00100, 5'b01100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 0, xfer_rdy = 0, burst_rdy = 0, fill_req = 0, fetch_req = 0;
  logic snp_strobe = 0, snp_inval = 0, snp_hit = 0, snp_dirty = 0;
  logic [LINE_W-1:0] fill_line = '0, fetch_line = '0, snp_line = '0;
  logic grant, modhit, kill, start, cach, wr, last;
  logic [LINE_W-1:0] line;
  logic [WORD_W-1:0] word;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bhs_ctrl i_bhs_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req), .xfer_rdy_i(xfer_rdy),
    .burst_rdy_i(burst_rdy), .fill_req_i(fill_req), .fill_line_i(fill_line),
    .fetch_req_i(fetch_req), .fetch_line_i(fetch_line), .snp_strobe_i(snp_strobe),
    .snp_inval_i(snp_inval), .snp_line_i(snp_line), .snp_hit_i(snp_hit),
    .snp_dirty_i(snp_dirty), .bus_grant_o(grant), .mod_hit_o(modhit),
    .line_kill_o(kill), .cyc_start_o(start), .cacheable_o(cach), .write_o(wr),
    .last_xfer_o(last), .line_o(line), .word_o(word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wb_burst(input logic [LINE_W-1:0] exp_line, input string tag);
    chk({tag, " start"}, {29'd0, start, wr, cach}, 32'd7);
    chk({tag, " line"}, 32'(line), 32'(exp_line));
    chk({tag, " word0"}, 32'(word), 0);
    chk({tag, " modhit"}, 32'(modhit), 1);
    tick();
    for (int k = 0; k < 4; k++) begin
      burst_rdy = 1; #1;
      chk("R6 wb word", 32'(word), 32'(k));
      chk("R6 wb last", 32'(last), 32'(k == 3));
      chk("R6 modhit held", 32'(modhit), 1);
      tick();
    end
    burst_rdy = 0; #1;
    chk("R6 modhit released", 32'(modhit), 0);
    chk("R6 no start after wb", 32'(start), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); #1;
    chk("R10 reset outputs", {23'd0, grant, modhit, kill, start, cach, wr, last, 2'b00},
        32'd0);
    chk("R10 reset word", 32'(word), 0);
    rst_n = 1; tick();

    // table of snoop cases
    for (int i = 0; i < 6; i++) begin
      logic [LINE_W-1:0] sl;
      sl = LINE_W'(32'h0000_1000 + i);
      bus_req = 1; #1;
      chk("R2 grant not yet", 32'(grant), 0);
      tick(); #1;
      chk("R2 grant raised", 32'(grant), 1);
      snp_strobe = 1; snp_hit = 1; snp_dirty = 1; snp_inval = 1; snp_line = '1; #1;
      chk("R3 first granted cycle ignored", 32'(kill), 0);
      tick();
      {snp_hit, snp_dirty, snp_inval} = SNP_TAB[i][4:2];
      snp_line = sl; #1;
      chk("R4 kill", 32'(kill), 32'(SNP_TAB[i][0]));
      tick();
      snp_strobe = 0; snp_hit = 0; snp_dirty = 0; snp_inval = 0; #1;
      chk("R4 modhit", 32'(modhit), 32'(SNP_TAB[i][1]));
      bus_req = 0; #1;
      chk("R2 grant held until sampled", 32'(grant), 1);
      tick(); #1;
      chk("R2 grant dropped", 32'(grant), 0);
      chk("R9 no start while releasing", 32'(start), 0);
      tick(); #1;
      if (SNP_TAB[i][1]) wb_burst(sl, "R5 wb");
      else begin
        chk("R5 no wb after clean", 32'(start), 0);
        chk("R4 modhit low", 32'(modhit), 0);
      end
      tick();
    end

    // hold during line fill
    fill_req = 1; fill_line = 28'h0ABCDEF; #1;
    chk("R11 no start yet", 32'(start), 0);
    tick();
    fill_req = 0; burst_rdy = 1; bus_req = 1; #1;
    chk("R11 fill start", {29'd0, start, wr, cach}, 32'd5);
    chk("R11 fill line", 32'(line), 32'h0ABCDEF);
    chk("R1 no grant at fill start", 32'(grant), 0);
    tick();
    for (int k = 0; k < 4; k++) begin
      #1;
      chk("R12 R11 fill word", 32'(word), 32'(k));
      chk("R11 fill last", 32'(last), 32'(k == 3));
      chk("R1 no grant in fill", 32'(grant), 0);
      tick();
    end
    burst_rdy = 0; #1;
    chk("R1 grant after fill", 32'(grant), 1);
    bus_req = 0; tick(); #1;
    chk("R2 grant off", 32'(grant), 0);

    // interrupted code fetch with a dirty snoop
    fetch_req = 1; fetch_line = 28'h0123456; tick();
    fetch_req = 0; #1;
    chk("R7 fetch start", {28'd0, start, cach, wr, last}, 32'h9);
    chk("R7 fetch line", 32'(line), 32'h0123456);
    chk("R7 fetch word0", 32'(word), 0);
    tick();
    xfer_rdy = 1; #1;
    chk("R7 no grant without req", 32'(grant), 0);
    tick();
    xfer_rdy = 0; #1;
    chk("R7 new start per word", 32'(start), 1);
    chk("R7 fetch word1", 32'(word), 1);
    tick();
    bus_req = 1; xfer_rdy = 1; #1;
    chk("R7 grant with ready", 32'(grant), 1);
    tick();
    xfer_rdy = 0; snp_strobe = 1; snp_hit = 1; snp_dirty = 1; snp_line = 28'h0777000; #1;
    chk("R3 snoop after fetch grant", 32'(grant), 1);
    chk("R4 kill without inval", 32'(kill), 0);
    tick();
    snp_strobe = 0; snp_hit = 0; snp_dirty = 0; #1;
    chk("R4 modhit from fetch snoop", 32'(modhit), 1);
    bus_req = 0; tick(); tick(); #1;
    wb_burst(28'h0777000, "R5 wb fetch");
    tick(); #1;
    chk("R8 resume start", 32'(start), 1);
    chk("R8 resume line", 32'(line), 32'h0123456);
    chk("R8 resume word", 32'(word), 2);
    tick();
    xfer_rdy = 1; tick();
    xfer_rdy = 0; #1;
    chk("R7 fetch word3", 32'(word), 3);
    tick();
    xfer_rdy = 1; tick();
    xfer_rdy = 0; #1;
    chk("R7 fetch done", {30'd0, start, grant}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule